// File: doc/BRIEF.md
# Core module system control registers

This block is the register file that a processor core module exposes to software for its own configuration and status. It answers a simple 32-bit register bus: a byte address, read and write strobes, write data, and read data that follows the address combinationally. A write takes effect at the clock edge on which its strobe is sampled. The accesses it reports, the reset request and the access error, appear as one-cycle pulses on the cycle after that edge.

The file holds the following registers:

- A fixed identifier word and a fixed bus-configuration word.
- Two oscillator setting registers. They can be written only after a 16-bit unlock key has been stored.
- A control register. Its bit 2 drives the boot-memory overlay enable, and its bit 3 turns into a reset request pulse instead of being stored.
- SDRAM and init configuration words. The SDRAM word carries a memory-size code that is fixed at build time by a parameter.
- Two flag words. Each is set through one address and cleared through another.
- A reference counter that advances at a nominal 24 MHz. It is derived from the system clock by fractional accumulation and counts from zero at reset.
- A read-only window that returns presence-detect bytes one per word.

An access to any address that is not decoded is ignored, reads as 0 and raises a one-cycle error flag.

Top module: `cm_sysctl`

## Requirements
- R1: Word 0 (byte 0x000) reads 0x411A3001. Word 1 (0x004) reads 0. Word 4 (0x010) reads 0x00100000. All three ignore writes.
- R2: A write to word 5 (0x014) stores the low 16 bits of the data as the lock value, which resets to 0. While the lock value is 0xA05F, word 5 reads 0x0001A05F. Otherwise word 5 reads the lock value zero-extended.
- R3: Word 2 (0x008, oscillator, reset 0x01000048) and word 7 (0x01C, auxiliary oscillator, reset 0x0007FEFF) take a write only while the lock value is 0xA05F. Otherwise the write leaves them unchanged.
- R4: A write to word 3 (0x00C, control, reset 0) replaces only bits 0 and 2 and keeps every other bit. The output remap_en equals the inverse of control bit 2, so remap_en is 1 after reset.
- R5: A write to word 3 whose data has bit 3 set makes reset_req high for exactly the one cycle after the write edge. Bit 3 is never stored.
- R6: Word 8 (0x020, SDRAM) resets to 0x00011122 ORed with a size code: 0x10 for MEM_MB >= 256, 0x0C for >= 128, 0x08 for >= 64, 0x04 for >= 32, else 0. Word 9 (0x024, init) resets to 0x00000112. Both words take full 32-bit writes, and mem_size always shows SDRAM bits 4:2.
- R7: A write to word 12 (0x030) ORs the data into the flags word, and a write to word 13 (0x034) clears the flag bits written as 1. Words 14 (0x038) and 15 (0x03C) do the same for the second flags word. Word 12 reads the flags and word 14 reads the second flags; both reset to 0.
- R8: Word 10 (0x028) reads floor(k*REF_HZ/CLK_HZ) modulo 2^32, where k is the number of rising clock edges since reset was released.
- R9: A read at byte offset 0x100 to 0x17F returns, zero-extended, the presence-detect byte whose index is the offset divided by 4. The bytes at indexes 73 to 83 hold the ASCII text "CORE-MODULE", and every other byte is 0. A read at 0x180 to 0x1FF returns 0. None of these reads raise an error.
- R10: Words 32 to 35 (0x080 to 0x08C) read 0, ignore writes and raise no error.
- R11: Any other access raises access_err for the one cycle after the access edge, reads 0 and changes no state. This covers:
  - reads of words 6, 11, 13, 15, 16 to 31 and 36 to 63;
  - reads at offset 0x200 and above;
  - writes to words 0, 1, 4, 6, 10, 11, 16 to 31 and 36 to 63;
  - writes at offset 0x100 and above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_rd | input | 1 | Read strobe, used for error reporting |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| remap_en | output | 1 | Boot-memory overlay enable, inverse of control bit 2 |
| reset_req | output | 1 | One-cycle reset request pulse |
| mem_size | output | 3 | SDRAM register bits 4:2 |
| access_err | output | 1 | One-cycle pulse after an access to an unimplemented address |

## Verification
The embedded properties assume that the bus strobes are low while reset is asserted and that each strobe is a clean level held for whole cycles. The properties that look one cycle back rely on this to see a quiet bus on the first edge after reset. The stimulus drives every strobe and address at the falling edge and keeps all strobes low through reset. The constrained-random phase issues only writes to decoded registers, so that any error pulse it sees counts as a fault. Illegal addresses, the presence-detect window, reserved words and the reset pulse are covered by directed accesses with known expected results.

// File: rtl/cm_sysctl_pkg.sv
package cm_sysctl_pkg;

    typedef enum logic [4:0] {
        SEL_NONE,
        SEL_ID,
        SEL_ZERO,
        SEL_OSC,
        SEL_CTRL,
        SEL_BUSCFG,
        SEL_LOCK,
        SEL_AUX,
        SEL_SDRAM,
        SEL_INIT,
        SEL_REFCNT,
        SEL_FLAGS,
        SEL_FLAGS_CLR,
        SEL_NVF,
        SEL_NVF_CLR,
        SEL_PD,
        SEL_PD_ZERO,
        SEL_RSVD
    } sel_e;

    localparam logic [31:0] ID_VALUE       = 32'h411A_3001;
    localparam logic [31:0] BUSCFG_VALUE   = 32'h0010_0000;
    localparam logic [15:0] UNLOCK_KEY     = 16'hA05F;
    localparam logic [31:0] LOCK_OPEN_READ = 32'h0001_A05F;
    localparam logic [31:0] OSC_RST        = 32'h0100_0048;
    localparam logic [31:0] AUX_RST        = 32'h0007_FEFF;
    localparam logic [31:0] SDRAM_RST      = 32'h0001_1122;
    localparam logic [31:0] INIT_RST       = 32'h0000_0112;
    localparam logic [31:0] CTRL_KEEP_MASK = 32'h0000_0005;
    localparam int          CTRL_REMAP_BIT = 2;
    localparam int          CTRL_RST_BIT   = 3;

    localparam int          PD_TEXT_LEN  = 11;
    localparam int          PD_TEXT_BASE = 73;
    localparam logic [8*PD_TEXT_LEN-1:0] PD_TEXT = "CORE-MODULE";

    typedef struct packed {
        logic [31:0] osc;
        logic [31:0] aux;
        logic [31:0] ctrl;
        logic [15:0] lock;
        logic [31:0] sdram;
        logic [31:0] init;
        logic [31:0] flags;
        logic [31:0] nvflags;
        logic        rst_req;
        logic        err;
    } regs_t;

    function automatic logic [4:0] size_code(input int mem_mb);
        if (mem_mb >= 256)      return 5'h10;
        else if (mem_mb >= 128) return 5'h0C;
        else if (mem_mb >= 64)  return 5'h08;
        else if (mem_mb >= 32)  return 5'h04;
        else                    return 5'h00;
    endfunction

    function automatic logic read_ok(input sel_e sel);
        return sel inside {SEL_ID, SEL_ZERO, SEL_OSC, SEL_CTRL, SEL_BUSCFG,
                           SEL_LOCK, SEL_AUX, SEL_SDRAM, SEL_INIT, SEL_REFCNT,
                           SEL_FLAGS, SEL_NVF, SEL_PD, SEL_PD_ZERO, SEL_RSVD};
    endfunction

    function automatic logic write_ok(input sel_e sel);
        return sel inside {SEL_OSC, SEL_CTRL, SEL_LOCK, SEL_AUX, SEL_SDRAM,
                           SEL_INIT, SEL_FLAGS, SEL_FLAGS_CLR, SEL_NVF,
                           SEL_NVF_CLR, SEL_RSVD};
    endfunction

endpackage

// File: rtl/cm_sysctl_decode.sv
module cm_sysctl_decode
    import cm_sysctl_pkg::*;
#(
    parameter int ADDR_W = 23
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [6:0]        pd_idx
);

    logic high_bits;
    logic unused_lsb;

    assign unused_lsb = ^addr[1:0];

    generate
        if (ADDR_W > 9) begin : g_high
            assign high_bits = |addr[ADDR_W-1:9];
        end else begin : g_no_high
            assign high_bits = 1'b0;
        end
    endgenerate

    assign pd_idx = addr[8:2];

    always_comb begin
        sel = SEL_NONE;
        if (high_bits) begin
            sel = SEL_NONE;
        end else if (addr[8]) begin
            sel = addr[7] ? SEL_PD_ZERO : SEL_PD;
        end else begin
            case (addr[7:2])
                6'd0:  sel = SEL_ID;
                6'd1:  sel = SEL_ZERO;
                6'd2:  sel = SEL_OSC;
                6'd3:  sel = SEL_CTRL;
                6'd4:  sel = SEL_BUSCFG;
                6'd5:  sel = SEL_LOCK;
                6'd7:  sel = SEL_AUX;
                6'd8:  sel = SEL_SDRAM;
                6'd9:  sel = SEL_INIT;
                6'd10: sel = SEL_REFCNT;
                6'd12: sel = SEL_FLAGS;
                6'd13: sel = SEL_FLAGS_CLR;
                6'd14: sel = SEL_NVF;
                6'd15: sel = SEL_NVF_CLR;
                6'd32, 6'd33, 6'd34, 6'd35: sel = SEL_RSVD;
                default: sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/cm_sysctl_pdrom.sv
module cm_sysctl_pdrom
    import cm_sysctl_pkg::*;
(
    input  logic [6:0] idx,
    output logic [7:0] data
);

    logic [PD_TEXT_LEN-1:0] hit;
    logic [7:0]             chr [PD_TEXT_LEN];

    generate
        for (genvar g = 0; g < PD_TEXT_LEN; g++) begin : g_char
            assign hit[g] = (int'(idx) == PD_TEXT_BASE + g);
            assign chr[g] = PD_TEXT[8*(PD_TEXT_LEN-1-g) +: 8];
        end
    endgenerate

    always_comb begin
        data = 8'h00;
        for (int i = 0; i < PD_TEXT_LEN; i++) begin
            if (hit[i]) data = chr[i];
        end
    end

    always_comb begin
        assert ($onehot0(hit)) else $error("p_pd_single_hit_r9");
    end

endmodule

// File: rtl/cm_sysctl_refcnt.sv
module cm_sysctl_refcnt #(
    parameter int CLK_HZ = 125_000_000,
    parameter int REF_HZ = 24_000_000,
    parameter int CNT_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);

    localparam int ACC_W = $clog2(CLK_HZ) + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t           cnt_d, cnt_q;
    logic [ACC_W:0] sum;

    always_comb begin
        cnt_d = cnt_q;
        sum   = {1'b0, cnt_q.acc} + (ACC_W+1)'(REF_HZ);
        if (sum >= (ACC_W+1)'(CLK_HZ)) begin
            cnt_d.acc = ACC_W'(sum - (ACC_W+1)'(CLK_HZ));
            cnt_d.cnt = cnt_q.cnt + 1'b1;
        end else begin
            cnt_d.acc = ACC_W'(sum);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q.cnt;

    p_acc_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.acc < ACC_W'(CLK_HZ));

    p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cnt_q.cnt == $past(cnt_q.cnt)) ||
                  (cnt_q.cnt == $past(cnt_q.cnt) + 1'b1)));

endmodule

// File: rtl/cm_sysctl.sv
module cm_sysctl
    import cm_sysctl_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int MEM_MB = 128,
    parameter int CLK_HZ = 125_000_000,
    parameter int REF_HZ = 24_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              remap_en,
    output logic              reset_req,
    output logic [2:0]        mem_size,
    output logic              access_err
);

    localparam logic [31:0] SDRAM_INIT = SDRAM_RST | {27'b0, size_code(MEM_MB)};
    localparam regs_t REGS_RST = '{
        osc:     OSC_RST,
        aux:     AUX_RST,
        ctrl:    32'h0,
        lock:    16'h0,
        sdram:   SDRAM_INIT,
        init:    INIT_RST,
        flags:   32'h0,
        nvflags: 32'h0,
        rst_req: 1'b0,
        err:     1'b0
    };

    sel_e        sel;
    logic [6:0]  pd_idx;
    logic [7:0]  pd_byte;
    logic [31:0] ref_count;
    logic        unlocked;
    regs_t       regs_d, regs_q;

    cm_sysctl_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (bus_addr),
        .sel    (sel),
        .pd_idx (pd_idx)
    );

    cm_sysctl_pdrom u_pdrom (
        .idx  (pd_idx),
        .data (pd_byte)
    );

    cm_sysctl_refcnt #(.CLK_HZ(CLK_HZ), .REF_HZ(REF_HZ), .CNT_W(32)) u_refcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .count (ref_count)
    );

    assign unlocked = (regs_q.lock == UNLOCK_KEY);

    always_comb begin
        regs_d         = regs_q;
        regs_d.rst_req = 1'b0;
        if (bus_wr) begin
            case (sel)
                SEL_OSC:       if (unlocked) regs_d.osc = bus_wdata;
                SEL_AUX:       if (unlocked) regs_d.aux = bus_wdata;
                SEL_CTRL: begin
                    regs_d.ctrl    = (regs_q.ctrl & ~CTRL_KEEP_MASK) |
                                     (bus_wdata & CTRL_KEEP_MASK);
                    regs_d.rst_req = bus_wdata[CTRL_RST_BIT];
                end
                SEL_LOCK:      regs_d.lock    = bus_wdata[15:0];
                SEL_SDRAM:     regs_d.sdram   = bus_wdata;
                SEL_INIT:      regs_d.init    = bus_wdata;
                SEL_FLAGS:     regs_d.flags   = regs_q.flags | bus_wdata;
                SEL_FLAGS_CLR: regs_d.flags   = regs_q.flags & ~bus_wdata;
                SEL_NVF:       regs_d.nvflags = regs_q.nvflags | bus_wdata;
                SEL_NVF_CLR:   regs_d.nvflags = regs_q.nvflags & ~bus_wdata;
                default: ;
            endcase
        end
        regs_d.err = (bus_wr && !write_ok(sel)) || (bus_rd && !read_ok(sel));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (sel)
            SEL_ID:     bus_rdata = ID_VALUE;
            SEL_OSC:    bus_rdata = regs_q.osc;
            SEL_CTRL:   bus_rdata = regs_q.ctrl;
            SEL_BUSCFG: bus_rdata = BUSCFG_VALUE;
            SEL_LOCK:   bus_rdata = unlocked ? LOCK_OPEN_READ : {16'h0, regs_q.lock};
            SEL_AUX:    bus_rdata = regs_q.aux;
            SEL_SDRAM:  bus_rdata = regs_q.sdram;
            SEL_INIT:   bus_rdata = regs_q.init;
            SEL_REFCNT: bus_rdata = ref_count;
            SEL_FLAGS:  bus_rdata = regs_q.flags;
            SEL_NVF:    bus_rdata = regs_q.nvflags;
            SEL_PD:     bus_rdata = {24'h0, pd_byte};
            default:    bus_rdata = 32'h0;
        endcase
    end

    assign remap_en   = ~regs_q.ctrl[CTRL_REMAP_BIT];
    assign reset_req  = regs_q.rst_req;
    assign mem_size   = regs_q.sdram[4:2];
    assign access_err = regs_q.err;

    p_lock_low16_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_LOCK) |=> (regs_q.lock == $past(bus_wdata[15:0])));

    p_osc_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (sel == SEL_OSC || sel == SEL_AUX) && regs_q.lock != UNLOCK_KEY)
        |=> ($stable(regs_q.osc) && $stable(regs_q.aux)));

    p_remap_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_CTRL) |=> (remap_en == !$past(bus_wdata[2])));

    p_ctrl_kept_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ctrl & ~CTRL_KEEP_MASK) == 32'h0);

    p_rst_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(bus_wr && bus_wdata[3]));

    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_FLAGS_CLR) |=> ((regs_q.flags & $past(bus_wdata)) == 32'h0));

    p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_RSVD) |-> (bus_rdata == 32'h0));

    p_err_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        access_err |-> $past(bus_wr || bus_rd));

endmodule

// File: tb/cm_sysctl_bench.sv
`timescale 1ns/1ps
module cm_sysctl_bench;

    localparam int ADDR_W = 23;
    localparam int MEM_MB = 128;
    localparam int CLK_HZ = 125_000_000;
    localparam int REF_HZ = 24_000_000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              remap_en, reset_req, access_err;
    logic [2:0]        mem_size;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_cyc = 0;
    bit done = 1'b0;

    logic [31:0] m_osc, m_aux, m_ctrl, m_sdram, m_init, m_flags, m_nv;
    logic [15:0] m_lock;

    cm_sysctl #(.ADDR_W(ADDR_W), .MEM_MB(MEM_MB), .CLK_HZ(CLK_HZ), .REF_HZ(REF_HZ)) u_cm_sysctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .remap_en   (remap_en),
        .reset_req  (reset_req),
        .mem_size   (mem_size),
        .access_err (access_err)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                             output logic got_err, output logic got_rst);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        got_err = access_err;
        got_rst = reset_req;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] data,
                            output logic got_err);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        data = bus_rdata;
        last_cyc = cyc;
        @(negedge clk);
        bus_rd = 1'b0;
        got_err = access_err;
    endtask

    function automatic logic [4:0] exp_size(input int mb);
        if (mb >= 256) return 5'h10;
        if (mb >= 128) return 5'h0C;
        if (mb >= 64)  return 5'h08;
        if (mb >= 32)  return 5'h04;
        return 5'h00;
    endfunction

    function automatic logic [31:0] exp_read(input int word);
        case (word)
            2:  return m_osc;
            3:  return m_ctrl;
            5:  return (m_lock == 16'hA05F) ? 32'h0001A05F : {16'h0, m_lock};
            7:  return m_aux;
            8:  return m_sdram;
            9:  return m_init;
            12: return m_flags;
            14: return m_nv;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input int word);
        case (word)
            2, 7:   return "R3";
            3:      return "R4";
            5:      return "R2";
            8, 9:   return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [31:0] exp_pd(input int idx);
        string txt = "CORE-MODULE";
        if (idx >= 73 && idx <= 83) return {24'h0, txt[idx-73]};
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_count(input int k);
        longint v = (longint'(k) * longint'(REF_HZ)) / longint'(CLK_HZ);
        return v[31:0];
    endfunction

    task automatic model_write(input int word, input logic [31:0] d);
        case (word)
            2:  if (m_lock == 16'hA05F) m_osc = d;
            3:  m_ctrl = (m_ctrl & ~32'h5) | (d & 32'h5);
            5:  m_lock = d[15:0];
            7:  if (m_lock == 16'hA05F) m_aux = d;
            8:  m_sdram = d;
            9:  m_init = d;
            12: m_flags = m_flags | d;
            13: m_flags = m_flags & ~d;
            14: m_nv = m_nv | d;
            15: m_nv = m_nv & ~d;
            default: ;
        endcase
    endtask

    task automatic wr_word(input int word, input logic [31:0] d, input string req);
        logic e, r;
        bus_write(ADDR_W'(word * 4), d, e, r);
        model_write(word, d);
        check({req, " no error on legal write"}, {31'h0, e}, 32'h0);
        check("R5 reset pulse", {31'h0, r}, {31'h0, (word == 3) && d[3]});
    endtask

    task automatic rd_word(input int word, input string req);
        logic [31:0] v;
        logic        e;
        bus_read(ADDR_W'(word * 4), v, e);
        check(req, v, exp_read(word));
        check({req, " no error on legal read"}, {31'h0, e}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic        e, r;
        int          seed;

        seed = $urandom(32'd7301);
        m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_ctrl = 0;
        m_sdram = 32'h00011122 | {27'h0, exp_size(MEM_MB)};
        m_init = 32'h112; m_flags = 0; m_nv = 0; m_lock = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        check("R4 remap_en after reset", {31'h0, remap_en}, 32'h1);
        check("R5 reset_req after reset", {31'h0, reset_req}, 32'h0);
        check("R11 access_err after reset", {31'h0, access_err}, 32'h0);
        check("R6 mem_size after reset", {29'h0, mem_size}, {29'h0, exp_size(MEM_MB)[4:2]});
        for (int w = 2; w <= 14; w++) begin
            if (w inside {2, 3, 5, 7, 8, 9, 12, 14}) rd_word(w, {tag_of(w), " reset value"});
        end

        // R1 constants
        bus_read(23'h000, v, e); check("R1 identifier", v, 32'h411A3001);
        bus_read(23'h004, v, e); check("R1 word1", v, 32'h0);
        bus_read(23'h010, v, e); check("R1 word4", v, 32'h00100000);
        bus_write(23'h000, 32'hFFFFFFFF, e, r);
        check("R11 write to identifier errors", {31'h0, e}, 32'h1);
        bus_read(23'h000, v, e); check("R1 identifier after write", v, 32'h411A3001);

        // R3 locked writes ignored, R2 lock readback
        wr_word(2, 32'hDEADBEEF, "R3");
        wr_word(7, 32'hCAFEF00D, "R3");
        rd_word(2, "R3 locked osc unchanged");
        rd_word(7, "R3 locked aux unchanged");
        wr_word(5, 32'h1234A05F, "R2");
        rd_word(5, "R2 unlocked readback");
        wr_word(2, 32'h00AA5500, "R3");
        wr_word(7, 32'h11223344, "R3");
        rd_word(2, "R3 unlocked osc write");
        rd_word(7, "R3 unlocked aux write");
        wr_word(5, 32'hFFFFBEEF, "R2");
        rd_word(5, "R2 stored lock low 16");

        // R4 control and remap
        wr_word(3, 32'hFFFFFFF7, "R4");
        rd_word(3, "R4 only bits 0 and 2 kept");
        check("R4 remap off with bit2", {31'h0, remap_en}, 32'h0);
        wr_word(3, 32'h00000001, "R4");
        check("R4 remap on with bit2 clear", {31'h0, remap_en}, 32'h1);

        // R5 reset pulse length
        wr_word(3, 32'h00000008, "R5");
        @(negedge clk);
        check("R5 pulse lasts one cycle", {31'h0, reset_req}, 32'h0);
        rd_word(3, "R5 bit3 not stored");

        // R6 sdram size field
        wr_word(8, 32'h00000010, "R6");
        check("R6 mem_size follows sdram", {29'h0, mem_size}, 32'h4);
        rd_word(8, "R6 sdram write");

        // R7 flags
        wr_word(12, 32'hF0F0000F, "R7");
        wr_word(13, 32'h30000003, "R7");
        rd_word(12, "R7 flags set clear");
        wr_word(14, 32'h0000FF00, "R7");
        wr_word(15, 32'h00000F00, "R7");
        rd_word(14, "R7 nv flags set clear");

        // R9 presence-detect window
        for (int off = 'h100; off < 'h200; off += 'h14) begin
            bus_read(ADDR_W'(off), v, e);
            check("R9 window byte", v, (off < 'h180) ? exp_pd(off / 4) : 32'h0);
            check("R9 window no error", {31'h0, e}, 32'h0);
        end
        bus_read(23'h124, v, e); check("R9 index 73", v, 32'h43);
        bus_read(23'h14C, v, e); check("R9 index 83", v, 32'h45);
        bus_read(23'h1FC, v, e); check("R9 top zero", v, 32'h0);
        bus_write(23'h124, 32'h0, e, r);
        check("R11 write to window errors", {31'h0, e}, 32'h1);
        bus_read(23'h124, v, e); check("R9 window unchanged", v, 32'h43);

        // R10 reserved words
        for (int w = 32; w <= 35; w++) begin
            bus_write(ADDR_W'(w * 4), 32'hFFFFFFFF, e, r);
            check("R10 reserved write no error", {31'h0, e}, 32'h0);
            bus_read(ADDR_W'(w * 4), v, e);
            check("R10 reserved reads 0", v, 32'h0);
            check("R10 reserved read no error", {31'h0, e}, 32'h0);
        end

        // R11 unimplemented
        bus_read(23'h018, v, e);
        check("R11 word6 read error", {31'h0, e}, 32'h1);
        check("R11 word6 reads 0", v, 32'h0);
        @(negedge clk);
        check("R11 error is one cycle", {31'h0, access_err}, 32'h0);
        bus_read(23'h034, v, e); check("R11 read of clear address", {31'h0, e}, 32'h1);
        bus_read(23'h040, v, e); check("R11 word16 read", {31'h0, e}, 32'h1);
        bus_read(23'h200, v, e); check("R11 beyond window read", {31'h0, e}, 32'h1);
        check("R11 beyond window reads 0", v, 32'h0);
        bus_write(23'h028, 32'h0, e, r); check("R11 write to counter", {31'h0, e}, 32'h1);
        bus_write(23'h400030, 32'hFFFFFFFF, e, r);
        check("R11 high address write", {31'h0, e}, 32'h1);
        rd_word(12, "R11 high write left flags");

        // R8 counter
        bus_read(23'h028, v, e);
        check("R8 reference count", v, exp_count(last_cyc));
        repeat (777) @(negedge clk);
        bus_read(23'h028, v, e);
        check("R8 reference count later", v, exp_count(last_cyc));

        // constrained random
        for (int i = 0; i < 300; i++) begin
            int          wl[10] = '{2, 3, 5, 7, 8, 9, 12, 13, 14, 15};
            int          rl[8]  = '{2, 3, 5, 7, 8, 9, 12, 14};
            int          w      = wl[$urandom_range(0, 9)];
            int          rw     = rl[$urandom_range(0, 7)];
            logic [31:0] d      = $urandom;
            if (w == 5 && $urandom_range(0, 1) == 1) d[15:0] = 16'hA05F;
            wr_word(w, d, tag_of(w));
            rd_word(rw, {tag_of(rw), " random readback"});
        end
        bus_read(23'h028, v, e);
        check("R8 reference count after random", v, exp_count(last_cyc));

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule